// File: doc/BRIEF.md
# Floating-Point Scoreboard Issue Controller

This block is the central hazard controller for a small set of floating-point functional units. It has no register renaming and no operand forwarding. Decoded instructions arrive one at a time on an issue port. Each one carries a unit kind, an opcode, a destination register and two source registers. The controller accepts them strictly in program order. An instruction it cannot accept holds the port, so every younger instruction waits behind it.

Once an instruction is accepted, the controller moves it through four steps: issue, operand read, execution and result write. For each unit it raises a read permission, a start pulse and a write-back permission. Execution itself happens outside the block. Each unit reports completion through its own done input.

Inside, the controller keeps two tables. The per-unit status table holds busy, opcode, destination, both sources, the producing unit of each source and a ready flag for each source. The per-register table records which unit will write each register. Hazards are handled by stalling. A structural conflict or a write-after-write conflict blocks issue. A read-after-write conflict delays the operand read. A write-after-read conflict delays write-back.

Top module: `sb_scoreboard`

## Requirements
- R1: After a synchronous active-low reset, every unit is free. All rd_grant, ex_start and wb_grant bits are 0, iss_fu is 0, and iss_ready is 1 for every kind code.
- R2: Kind code 0 (integer/load) goes to unit 0. Kind code 1 (multiply) goes to the lower-numbered free unit of units 1 and 2. Kind code 2 (add) goes to unit 3. Kind code 3 (divide) goes to unit 4. In the accept cycle (iss_valid and iss_ready both 1), iss_fu is one-hot on the chosen unit.
- R3: When no unit of the requested kind is free, iss_ready is 0 and the instruction stays on the port.
- R4: An instruction whose destination is the destination of any busy unit is not accepted before the cycle after that unit's wb_grant.
- R5: An instruction accepted in cycle t whose sources have no pending writer gets rd_grant on its unit in cycle t+1.
- R6: An instruction whose source is pending on another unit gets rd_grant in the cycle after that unit's wb_grant.
- R7: ex_start is a one-cycle pulse in the cycle directly after rd_grant.
- R8: exec_done is accepted only in the cycles after ex_start and before write-back. When done is seen in cycle c and no write-after-read conflict exists, wb_grant follows in cycle c+1. A done pulse at any other time is ignored.
- R9: wb_grant is withheld while another busy unit still has to read the old value of the destination register. It is given in the cycle after that unit's rd_grant.
- R10: In its wb_grant cycle, a unit releases itself, its register and every waiting reader of that register. A new instruction of that kind or to that register is accepted in the next cycle.
- R11: In the cycle after acceptance, fu_op and fu_dst of the chosen unit show the opcode and destination that were issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An instruction is offered on the issue port |
| iss_kind | input | 2 | Unit kind code: 0 int/load, 1 mul, 2 add, 3 div |
| iss_op | input | OP_W | Opcode passed through to the unit |
| iss_dst | input | REG_W | Destination register |
| iss_src1 | input | REG_W | First source register |
| iss_src2 | input | REG_W | Second source register |
| iss_ready | output | 1 | The offered instruction is accepted at the next edge |
| iss_fu | output | NFU | One-hot unit that takes the instruction this cycle |
| rd_grant | output | NFU | Per unit: read both operands this cycle |
| ex_start | output | NFU | Per unit: begin execution this cycle |
| wb_grant | output | NFU | Per unit: write the result this cycle |
| exec_done | input | NFU | Per unit: execution has finished |
| fu_op | output | NFU x OP_W | Opcode held by each unit |
| fu_dst | output | NFU x REG_W | Destination held by each unit |

## Verification
Single independent instructions of every kind are swept over latencies 1 to 4. They pin down the fixed read, start and write-back spacing and the unit routing. Dependent pairs over all kind combinations put a source on a pending register, which separates a correct read wake-up from an early or lost one. Spurious done pulses during operand waits and while idle show that completion is only taken during execution. Pairs sharing a destination separate the issue stall from the structural stall, which is tried on its own with back-to-back adds and three multiplies. A long divide feeding a waiting reader, with a short multiply overwriting the reader's other source, exposes the write-after-read hold. A control run with unrelated sources shows that the same multiply then retires at its natural time.

// File: rtl/sb_pkg.sv
// Shared definitions for the scoreboard: unit population, tag encoding,
// kind codes and the per-unit step sequence.
// Assumes units are numbered by kind: int/load first, then multipliers,
// adders, dividers. Tag 0 means "no pending writer"; unit u has tag u+1.
package sb_pkg;

    localparam int N_INT = 1;
    localparam int N_MUL = 2;
    localparam int N_ADD = 1;
    localparam int N_DIV = 1;
    localparam int NFU   = N_INT + N_MUL + N_ADD + N_DIV;
    localparam int TAG_W = $clog2(NFU + 1);

    typedef enum logic [1:0] {
        KIND_INT = 2'd0,
        KIND_MUL = 2'd1,
        KIND_ADD = 2'd2,
        KIND_DIV = 2'd3
    } fu_kind_e;

    typedef enum logic [2:0] {
        ST_FREE,
        ST_OPERANDS,
        ST_START,
        ST_RUN,
        ST_RESULT
    } fu_state_e;

    // Kind served by unit number idx.
    function automatic fu_kind_e kind_of(input int idx);
        if (idx < N_INT)
            return KIND_INT;
        else if (idx < N_INT + N_MUL)
            return KIND_MUL;
        else if (idx < N_INT + N_MUL + N_ADD)
            return KIND_ADD;
        return KIND_DIV;
    endfunction

    // Result tag carried by unit number idx.
    function automatic logic [TAG_W-1:0] tag_of(input int idx);
        return TAG_W'(idx + 1);
    endfunction

endpackage

// File: rtl/sb_issue_sel.sv
// Issue selector: picks the lowest-numbered free unit of the requested
// kind and decides whether the offered instruction can be accepted.
// Assumes dst_free already reflects the register result table.
module sb_issue_sel
    import sb_pkg::*;
(
    input  logic           iss_valid,
    input  logic [1:0]     iss_kind,
    input  logic           dst_free,
    input  logic [NFU-1:0] fu_busy,
    output logic           iss_ready,
    output logic [NFU-1:0] alloc
);

    logic [NFU-1:0] cand;
    logic [NFU-1:0] pick;
    logic           found;

    // Mark every free unit whose kind matches the request.
    for (genvar u = 0; u < NFU; u++) begin : g_cand
        assign cand[u] = !fu_busy[u] && (kind_of(u) == fu_kind_e'(iss_kind));
    end

    // Keep only the lowest-numbered candidate.
    always_comb begin : lowest_pick
        pick  = '0;
        found = 1'b0;
        for (int u = 0; u < NFU; u++) begin
            if (cand[u] && !found) begin
                pick[u] = 1'b1;
                found   = 1'b1;
            end
        end
    end

    assign iss_ready = found && dst_free;
    assign alloc     = (iss_valid && iss_ready) ? pick : '0;

endmodule

// File: rtl/sb_fu_entry.sv
// Status entry for one functional unit. It holds the issued instruction,
// the producer tags and ready flags of both sources, and the unit's step.
// It grants the operand read, pulses the start, waits for done and then
// requests write-back.
// Assumes alloc only arrives while the entry is free, and that the source
// tags at allocation already exclude a writer retiring in the same cycle.
module sb_fu_entry
    import sb_pkg::*;
#(
    parameter int REG_W = 4,
    parameter int OP_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [OP_W-1:0]  a_op,
    input  logic [REG_W-1:0] a_dst,
    input  logic [REG_W-1:0] a_src1,
    input  logic [REG_W-1:0] a_src2,
    input  logic [TAG_W-1:0] a_q1,
    input  logic [TAG_W-1:0] a_q2,
    input  logic             exec_done,
    input  logic             wb_go,
    input  logic [NFU-1:0]   wb_vec,
    output logic             busy,
    output logic             rd_grant,
    output logic             ex_start,
    output logic             wb_req,
    output logic [OP_W-1:0]  op,
    output logic [REG_W-1:0] fi,
    output logic [REG_W-1:0] fj,
    output logic [REG_W-1:0] fk,
    output logic             rj,
    output logic             rk
);

    fu_state_e        st;
    logic [TAG_W-1:0] qj;
    logic [TAG_W-1:0] qk;
    logic             q1_hit;
    logic             q2_hit;

    // Detect a write-back this cycle by the producer of either source.
    always_comb begin : wakeup_match
        q1_hit = 1'b0;
        q2_hit = 1'b0;
        for (int v = 0; v < NFU; v++) begin
            if (wb_vec[v] && (qj == tag_of(v))) q1_hit = 1'b1;
            if (wb_vec[v] && (qk == tag_of(v))) q2_hit = 1'b1;
        end
    end

    assign busy     = (st != ST_FREE);
    assign rd_grant = (st == ST_OPERANDS) && rj && rk;
    assign ex_start = (st == ST_START);
    assign wb_req   = (st == ST_RESULT);

    // Advance the unit through its steps and maintain its status fields.
    always_ff @(posedge clk) begin : status_update
        if (!rst_n) begin
            st <= ST_FREE;
            op <= '0;
            fi <= '0;
            fj <= '0;
            fk <= '0;
            qj <= '0;
            qk <= '0;
            rj <= 1'b0;
            rk <= 1'b0;
        end else begin
            case (st)
                ST_FREE: begin
                    if (alloc) begin
                        st <= ST_OPERANDS;
                        op <= a_op;
                        fi <= a_dst;
                        fj <= a_src1;
                        fk <= a_src2;
                        qj <= a_q1;
                        qk <= a_q2;
                        rj <= (a_q1 == '0);
                        rk <= (a_q2 == '0);
                    end
                end
                ST_OPERANDS: begin
                    if (rj && rk) begin
                        st <= ST_START;
                        rj <= 1'b0;
                        rk <= 1'b0;
                    end else begin
                        if (q1_hit) begin
                            rj <= 1'b1;
                            qj <= '0;
                        end
                        if (q2_hit) begin
                            rk <= 1'b1;
                            qk <= '0;
                        end
                    end
                end
                ST_START: st <= ST_RUN;
                ST_RUN: begin
                    if (exec_done) st <= ST_RESULT;
                end
                ST_RESULT: begin
                    if (wb_go) st <= ST_FREE;
                end
                default: st <= ST_FREE;
            endcase
        end
    end

endmodule

// File: rtl/sb_regstat.sv
// Register result-status table: for each register, the tag of the unit
// that will write it, or 0 when no writer is outstanding.
// Assumes a set never targets a register that is being cleared in the
// same cycle (issue requires the destination to be free).
module sb_regstat
    import sb_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int REG_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        set_en,
    input  logic [REG_W-1:0]            set_reg,
    input  logic [TAG_W-1:0]            set_tag,
    input  logic [NFU-1:0]              clr_vec,
    input  logic [NFU-1:0][REG_W-1:0]   clr_reg,
    output logic [NREG-1:0][TAG_W-1:0]  reg_tag
);

    logic [NREG-1:0] clr_hit;

    // Find registers released by a retiring unit that still owns them.
    always_comb begin : release_scan
        clr_hit = '0;
        for (int r = 0; r < NREG; r++) begin
            for (int u = 0; u < NFU; u++) begin
                if (clr_vec[u] && (clr_reg[u] == REG_W'(r)) && (reg_tag[r] == tag_of(u)))
                    clr_hit[r] = 1'b1;
            end
        end
    end

    // Record new writers and drop retired ones.
    always_ff @(posedge clk) begin : table_update
        if (!rst_n) begin
            reg_tag <= '0;
        end else begin
            for (int r = 0; r < NREG; r++) begin
                if (set_en && (set_reg == REG_W'(r)))
                    reg_tag[r] <= set_tag;
                else if (clr_hit[r])
                    reg_tag[r] <= '0;
            end
        end
    end

endmodule

// File: rtl/sb_scoreboard.sv
// Scoreboard top: in-order issue, stall-based hazard control and
// per-unit read / start / write-back permission for the FP units.
// Assumes execution happens outside and reports through exec_done; the
// register file datapath acts on the permission outputs.
module sb_scoreboard
    import sb_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int OP_W  = 4,
    parameter int REG_W = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       iss_valid,
    input  logic [1:0]                 iss_kind,
    input  logic [OP_W-1:0]            iss_op,
    input  logic [REG_W-1:0]           iss_dst,
    input  logic [REG_W-1:0]           iss_src1,
    input  logic [REG_W-1:0]           iss_src2,
    output logic                       iss_ready,
    output logic [NFU-1:0]             iss_fu,
    output logic [NFU-1:0]             rd_grant,
    output logic [NFU-1:0]             ex_start,
    output logic [NFU-1:0]             wb_grant,
    input  logic [NFU-1:0]             exec_done,
    output logic [NFU-1:0][OP_W-1:0]   fu_op,
    output logic [NFU-1:0][REG_W-1:0]  fu_dst
);

    logic [NFU-1:0]              fu_busy;
    logic [NFU-1:0]              wb_req;
    logic [NFU-1:0]              war_hold;
    logic [NFU-1:0]              wb_go;
    logic [NFU-1:0]              alloc;
    logic [NFU-1:0][REG_W-1:0]   fi_arr;
    logic [NFU-1:0][REG_W-1:0]   fj_arr;
    logic [NFU-1:0][REG_W-1:0]   fk_arr;
    logic [NFU-1:0]              rj_arr;
    logic [NFU-1:0]              rk_arr;
    logic [NREG-1:0][TAG_W-1:0]  reg_tag;
    logic [TAG_W-1:0]            src1_q;
    logic [TAG_W-1:0]            src2_q;
    logic [TAG_W-1:0]            new_tag;
    logic                        dst_free;

    assign dst_free = (reg_tag[iss_dst] == '0);

    sb_issue_sel u_sel (
        .iss_valid (iss_valid),
        .iss_kind  (iss_kind),
        .dst_free  (dst_free),
        .fu_busy   (fu_busy),
        .iss_ready (iss_ready),
        .alloc     (alloc)
    );

    // Look up source producers, treating a writer retiring now as done.
    always_comb begin : source_tags
        src1_q = reg_tag[iss_src1];
        src2_q = reg_tag[iss_src2];
        for (int v = 0; v < NFU; v++) begin
            if (wb_go[v] && (src1_q == tag_of(v))) src1_q = '0;
            if (wb_go[v] && (src2_q == tag_of(v))) src2_q = '0;
        end
    end

    // Convert the one-hot allocation into the tag stored for the destination.
    always_comb begin : alloc_tag
        new_tag = '0;
        for (int u = 0; u < NFU; u++) begin
            if (alloc[u]) new_tag = tag_of(u);
        end
    end

    // Hold a unit's write-back while another unit still must read its target.
    always_comb begin : war_scan
        war_hold = '0;
        for (int u = 0; u < NFU; u++) begin
            for (int f = 0; f < NFU; f++) begin
                if (f != u) begin
                    if ((rj_arr[f] && (fj_arr[f] == fi_arr[u])) ||
                        (rk_arr[f] && (fk_arr[f] == fi_arr[u])))
                        war_hold[u] = 1'b1;
                end
            end
        end
    end

    assign wb_go = wb_req & ~war_hold;

    for (genvar u = 0; u < NFU; u++) begin : g_fu
        sb_fu_entry #(
            .REG_W (REG_W),
            .OP_W  (OP_W)
        ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc     (alloc[u]),
            .a_op      (iss_op),
            .a_dst     (iss_dst),
            .a_src1    (iss_src1),
            .a_src2    (iss_src2),
            .a_q1      (src1_q),
            .a_q2      (src2_q),
            .exec_done (exec_done[u]),
            .wb_go     (wb_go[u]),
            .wb_vec    (wb_go),
            .busy      (fu_busy[u]),
            .rd_grant  (rd_grant[u]),
            .ex_start  (ex_start[u]),
            .wb_req    (wb_req[u]),
            .op        (fu_op[u]),
            .fi        (fi_arr[u]),
            .fj        (fj_arr[u]),
            .fk        (fk_arr[u]),
            .rj        (rj_arr[u]),
            .rk        (rk_arr[u])
        );
    end

    sb_regstat #(
        .NREG  (NREG),
        .REG_W (REG_W)
    ) u_regstat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (|alloc),
        .set_reg (iss_dst),
        .set_tag (new_tag),
        .clr_vec (wb_go),
        .clr_reg (fi_arr),
        .reg_tag (reg_tag)
    );

    assign iss_fu   = alloc;
    assign wb_grant = wb_go;
    assign fu_dst   = fi_arr;

endmodule

// File: rtl/sb_scoreboard_chk.sv
// Property checker for the scoreboard, attached by bind. It observes the
// port-level permissions and the per-unit busy state.
module sb_scoreboard_chk
    import sb_pkg::*;
#(
    parameter int REG_W = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      iss_valid,
    input logic                      iss_ready,
    input logic [NFU-1:0]            iss_fu,
    input logic [NFU-1:0]            rd_grant,
    input logic [NFU-1:0]            ex_start,
    input logic [NFU-1:0]            wb_grant,
    input logic [NFU-1:0]            fu_busy,
    input logic [NFU-1:0][REG_W-1:0] fu_dst
);

    a_r2_issue_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |-> ($countones(iss_fu) == 1));

    a_r3_no_alloc_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !(iss_valid && iss_ready) |-> (iss_fu == '0));

    for (genvar u = 0; u < NFU; u++) begin : g_unit
        a_r2_target_free: assert property (@(posedge clk) disable iff (!rst_n)
            iss_fu[u] |-> !fu_busy[u]);

        a_r7_start_after_read: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[u] |=> ex_start[u]);

        a_r7_start_single: assert property (@(posedge clk) disable iff (!rst_n)
            ex_start[u] |=> !ex_start[u]);

        a_r10_free_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
            wb_grant[u] |=> !fu_busy[u]);

        a_r8_one_step: assert property (@(posedge clk) disable iff (!rst_n)
            $countones({rd_grant[u], ex_start[u], wb_grant[u]}) <= 1);

        for (genvar w = u + 1; w < NFU; w++) begin : g_pair
            a_r4_no_waw: assert property (@(posedge clk) disable iff (!rst_n)
                !(fu_busy[u] && fu_busy[w] && (fu_dst[u] == fu_dst[w])));
        end
    end

endmodule

bind sb_scoreboard sb_scoreboard_chk #(
    .REG_W (REG_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .iss_fu    (iss_fu),
    .rd_grant  (rd_grant),
    .ex_start  (ex_start),
    .wb_grant  (wb_grant),
    .fu_busy   (fu_busy),
    .fu_dst    (fu_dst)
);

// File: tb/sb_scoreboard_tb_top.sv
// Self-checking bench: sweeps kinds, latencies and dependency patterns and
// checks event cycles against arithmetic expectations.
module sb_scoreboard_tb_top;
    import sb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 16;
    localparam int OP_W       = 4;
    localparam int REG_W      = 4;
    localparam int WATCHDOG   = 150000;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      iss_valid = 1'b0;
    logic [1:0]                iss_kind = '0;
    logic [OP_W-1:0]           iss_op = '0;
    logic [REG_W-1:0]          iss_dst = '0;
    logic [REG_W-1:0]          iss_src1 = '0;
    logic [REG_W-1:0]          iss_src2 = '0;
    logic                      iss_ready;
    logic [NFU-1:0]            iss_fu;
    logic [NFU-1:0]            rd_grant;
    logic [NFU-1:0]            ex_start;
    logic [NFU-1:0]            wb_grant;
    logic [NFU-1:0]            exec_done;
    logic [NFU-1:0][OP_W-1:0]  fu_op;
    logic [NFU-1:0][REG_W-1:0] fu_dst;

    logic [NFU-1:0] model_done = '0;
    logic [NFU-1:0] force_done = '0;
    int             lat   [NFU];
    int             cnt   [NFU];
    logic           armed [NFU];
    int             t_rd  [NFU];
    int             t_ex  [NFU];
    int             t_wb  [NFU];
    int             cyc = 0;
    int             n_chk = 0;
    int             n_bad = 0;

    assign exec_done = model_done | force_done;

    sb_scoreboard #(.NREG(NREG), .OP_W(OP_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_kind(iss_kind),
        .iss_op(iss_op), .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .iss_ready(iss_ready), .iss_fu(iss_fu), .rd_grant(rd_grant), .ex_start(ex_start),
        .wb_grant(wb_grant), .exec_done(exec_done), .fu_op(fu_op), .fu_dst(fu_dst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Unit latency model and event recorder, evaluated mid-cycle.
    always @(negedge clk) begin
        for (int u = 0; u < NFU; u++) begin
            model_done[u] = 1'b0;
            if (!rst_n) begin
                armed[u] = 1'b0;
                cnt[u]   = 0;
                t_rd[u]  = -1;
                t_ex[u]  = -1;
                t_wb[u]  = -1;
            end else begin
                if (rd_grant[u]) t_rd[u] = cyc;
                if (wb_grant[u]) t_wb[u] = cyc;
                if (ex_start[u]) begin
                    t_ex[u]  = cyc;
                    cnt[u]   = lat[u];
                    armed[u] = 1'b1;
                end else if (armed[u]) begin
                    cnt[u] = cnt[u] - 1;
                    if (cnt[u] == 0) begin
                        model_done[u] = 1'b1;
                        armed[u]      = 1'b0;
                    end
                end
            end
        end
    end

    always @(posedge clk) begin
        if (cyc >= WATCHDOG) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog (all requirements) actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int l);
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        iss_valid = 1'b0;
        force_done = '0;
        for (int u = 0; u < NFU; u++) lat[u] = l;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic issue(input int kind, input int dst, input int s1, input int s2,
                         input int op, output int acc, output int unit);
        @(negedge clk);
        iss_valid = 1'b1;
        iss_kind  = 2'(kind);
        iss_dst   = REG_W'(dst);
        iss_src1  = REG_W'(s1);
        iss_src2  = REG_W'(s2);
        iss_op    = OP_W'(op);
        #1;
        while (!iss_ready) begin
            @(negedge clk);
            #1;
        end
        acc  = cyc;
        unit = -1;
        for (int u = 0; u < NFU; u++) if (iss_fu[u]) unit = u;
        @(posedge clk);
        #1;
        iss_valid = 1'b0;
    endtask

    task automatic wait_wb(input int u);
        while (t_wb[u] < 0) begin
            @(posedge clk);
            #1;
        end
    endtask

    function automatic int unit_for(input int kind);
        case (kind)
            0: return 0;
            1: return 1;
            2: return 3;
            default: return 4;
        endcase
    endfunction

    initial begin
        int a1, a2, a3, u1, u2, u3;

        // R1 reset state and R8 done ignored while idle.
        do_reset(2);
        @(negedge clk);
        #1;
        check("R1 grants idle", int'(rd_grant | ex_start | wb_grant), 0);
        check("R1 iss_fu idle", int'(iss_fu), 0);
        for (int k = 0; k < 4; k++) begin
            iss_kind = 2'(k);
            #1;
            check("R1 ready per kind", int'(iss_ready), 1);
        end
        force_done = '1;
        @(posedge clk);
        #1;
        force_done = '0;
        repeat (4) @(posedge clk);
        #1;
        for (int u = 0; u < NFU; u++) check("R8 idle done ignored", t_wb[u], -1);

        // R2 R5 R7 R8 R11: single instruction per kind and latency.
        for (int k = 0; k < 4; k++) begin
            for (int l = 1; l <= 4; l++) begin
                do_reset(l);
                issue(k, k + 1, 8, 9, k * 4 + l - 1, a1, u1);
                check("R2 unit routing", u1, unit_for(k));
                if (u1 >= 0) begin
                    check("R11 fu_op", int'(fu_op[u1]), k * 4 + l - 1);
                    check("R11 fu_dst", int'(fu_dst[u1]), k + 1);
                    wait_wb(u1);
                    check("R5 read cycle", t_rd[u1], a1 + 1);
                    check("R7 start cycle", t_ex[u1], a1 + 2);
                    check("R8 write-back cycle", t_wb[u1], a1 + 3 + l);
                end
            end
        end

        // R6 R10 R8: read-after-write over kind pairs.
        for (int pk = 0; pk < 4; pk++) begin
            for (int ck = 0; ck < 4; ck++) begin
                if (pk == ck && pk != 1) continue;
                for (int l = 1; l <= 3; l += 2) begin
                    do_reset(l);
                    issue(pk, 5, 10, 11, 1, a1, u1);
                    if (l == 1) issue(ck, 6, 5, 12, 2, a2, u2);
                    else        issue(ck, 6, 12, 5, 2, a2, u2);
                    if (u1 < 0 || u2 < 0) begin
                        check("R2 dependent pair routed", -1, 0);
                        continue;
                    end
                    force_done[u2] = 1'b1;
                    @(posedge clk);
                    #1;
                    force_done[u2] = 1'b0;
                    wait_wb(u2);
                    check("R5 producer read", t_rd[u1], a1 + 1);
                    check("R6 consumer read after producer write", t_rd[u2], t_wb[u1] + 1);
                    check("R8 early done ignored", t_wb[u2], t_rd[u2] + 2 + l);
                end
            end
        end

        // R4 R10: write-after-write stall.
        for (int pk = 0; pk < 4; pk++) begin
            for (int l = 1; l <= 3; l++) begin
                do_reset(l);
                issue(pk, 7, 1, 2, 3, a1, u1);
                issue((pk + 1) % 4, 7, 3, 4, 4, a2, u2);
                if (u1 < 0 || u2 < 0) begin
                    check("R2 waw pair routed", -1, 0);
                    continue;
                end
                check("R4 issue after writer retires", a2, t_wb[u1] + 1);
                wait_wb(u2);
                check("R10 register reusable", t_wb[u2], a2 + 3 + l);
            end
        end

        // R3 R10 R2: structural stalls.
        for (int l = 1; l <= 3; l++) begin
            do_reset(l);
            issue(2, 1, 8, 9, 0, a1, u1);
            issue(2, 2, 8, 9, 0, a2, u2);
            check("R3 second add waits", a2, t_wb[3] + 1);
            check("R10 adder reused", u2, 3);

            do_reset(l);
            issue(1, 1, 8, 9, 0, a1, u1);
            issue(1, 2, 8, 9, 0, a2, u2);
            check("R2 first mul unit", u1, 1);
            check("R2 second mul unit", u2, 2);
            check("R2 muls back to back", a2, a1 + 1);
            issue(1, 3, 8, 9, 0, a3, u3);
            check("R3 third mul waits", a3, t_wb[1] + 1);
            check("R2 third mul lowest free", u3, 1);
        end

        // R9: write-after-read hold, with a control run (variant 2).
        for (int l = 2; l <= 6; l++) begin
            for (int v = 0; v < 3; v++) begin
                do_reset(1);
                lat[4] = l;
                issue(3, 3, 8, 9, 0, a1, u1);
                if (v == 0)      issue(2, 4, 3, 5, 0, a2, u2);
                else if (v == 1) issue(2, 4, 5, 3, 0, a2, u2);
                else             issue(2, 4, 8, 9, 0, a2, u2);
                issue(1, 5, 6, 7, 0, a3, u3);
                wait_wb(1);
                wait_wb(3);
                if (v < 2) begin
                    check("R6 reader waits on divide", t_rd[3], t_wb[4] + 1);
                    check("R9 overwrite held until read", t_wb[1], t_rd[3] + 1);
                end else begin
                    check("R9 no reader no hold", t_wb[1], a3 + 4);
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule